// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two binary32 operands and returns a binary32 result, along with flags that report when the result was too large or too small to encode. The operand fields are unpacked and the implied leading one is restored. The operand with the smaller magnitude is shifted right so that both share the larger exponent. The significands are then summed or differenced according to the effective sign, and the result is renormalized, rounded and packed again.

The work runs in a three-stage pipeline with no back-pressure:

- **Stage 1** unpacks and aligns the operands.
- **Stage 2** adds or subtracts and normalizes.
- **Stage 3** rounds, checks the exponent range and packs the result.

A new operation can be accepted on every cycle. Its result appears three clock edges later, marked by a valid strobe.

Top module: `fp_addsub`

## Requirements
- R1: Operands use the binary32 layout: sign in bit 31, biased exponent in bits 30:23 and stored fraction in bits 22:0, with an implied leading one for exponents 1 to 254. An operand with exponent field 0 is treated as zero, whatever its fraction holds. The block computes `y_o = a_i + b_i` when `sub_i` is 0 and `y_o = a_i - b_i` when `sub_i` is 1.
- R2: For finite operands whose result is normal, `y_o` is the exact sum rounded to 24 significant bits with round to nearest, ties to even. This includes operands whose exponents differ by more than the significand width.
- R3: If the rounded biased exponent reaches 255 or more, `y_o` is an infinity carrying the result sign (exponent 8'hFF, fraction 0) and `ovf_o` is 1.
- R4: If the rounded biased exponent is 0 or less, `y_o` is a zero carrying the result sign and `unf_o` is 1. No subnormal result is ever produced.
- R5: On an effective subtraction, the smaller magnitude is taken from the larger one, and the result sign is the sign of the larger-magnitude operand (after `sub_i` has been applied to `b_i`).
- R6: Any result that is exactly zero, including an exact cancellation and the sum of two zeros of any sign, is +0 (32'h0000_0000) with both flags 0.
- R7: If either operand has exponent field 255, `y_o` is whichever operand has the larger value of bits 30:0, passed through unchanged. For `b_i` this means its effective sign after `sub_i` is applied. On a tie `a_i` is chosen. Both flags are 0.
- R8: `valid_o` is high exactly three cycles after `valid_i` was high. Back-to-back operations are accepted every cycle, and idle cycles produce idle outputs.
- R9: While `rst_ni` is low, `valid_o`, `y_o`, `ovf_o` and `unf_o` are all 0.
- R10: Before rounding, every nonzero normal result has its significand renormalized into [2^23, 2^24), and the exponent is adjusted by the shift. This applies whether the sum carried out or the difference lost many leading bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present on the inputs |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| valid_o | output | 1 | Result present on the outputs |
| y_o | output | 32 | Result, binary32 |
| ovf_o | output | 1 | Result exponent overflowed, infinity returned |
| unf_o | output | 1 | Result exponent underflowed, zero returned |

## Verification

**Directed patterns.** These pin down the main edge behaviours:

- Equal-exponent additions exercise the carry-out right shift.
- Near-equal subtractions force long left renormalization and exact cancellation.
- Midpoint-tie sums show that rounding goes to even and not always up.
- Extreme-exponent pairs separate overflow from underflow and their signs.

**Random patterns.** Random operands are drawn in four families, each aimed at a different stage:

- Fully random operands stress the far-apart alignment and sticky path.
- Close exponents stress the adder and the rounding.
- Sign-flipped near-duplicates stress the leading-zero shifter.
- Extreme exponents stress the range checks.

**Pass-through and timing.** Infinity and NaN operands confirm that the larger operand is passed through and the normal path is bypassed. Interleaved idle cycles confirm that the valid strobe tracks each operation through the three stages.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;            // guard, round, sticky
  localparam int SH_W    = $clog2(EXT_W + 1);
  localparam int ES_W    = EXP_W + 2;            // signed working exponent
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXT_W-1:0]  mx;
    logic [EXT_W-1:0]  my;
    logic [EXP_W-1:0]  ex;
    logic              eff_sub;
    logic              special;
    logic [WORD_W-1:0] spec_val;
  } align_t;

  typedef struct packed {
    logic                    sign;
    logic [EXT_W-1:0]        norm;
    logic signed [ES_W-1:0]  exp;
    logic                    zero;
    logic                    special;
    logic [WORD_W-1:0]       spec_val;
  } norm_t;

  function automatic logic [SH_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [SH_W-1:0] n;
    logic found;
    n = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        n = SH_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              valid_o,
  output align_t            st_o
);
  localparam int WIDE_W = SIG_W + EXT_W;

  logic [WORD_W-1:0] b_eff, x, y;
  logic [EXP_W-1:0]  ex, ey, diff;
  logic [SIG_W-1:0]  sx, sy;
  logic [SH_W-1:0]   dsh;
  logic [WIDE_W-1:0] wide;
  align_t            st_d;

  always_comb begin
    b_eff = {b_i[WORD_W-1] ^ sub_i, b_i[WORD_W-2:0]};
    // larger magnitude goes to x; ties keep a
    if (a_i[WORD_W-2:0] >= b_i[WORD_W-2:0]) begin
      x = a_i;
      y = b_eff;
    end else begin
      x = b_eff;
      y = a_i;
    end
    ex   = x[WORD_W-2:FRAC_W];
    ey   = y[WORD_W-2:FRAC_W];
    sx   = (ex != '0) ? {1'b1, x[FRAC_W-1:0]} : '0;
    sy   = (ey != '0) ? {1'b1, y[FRAC_W-1:0]} : '0;
    diff = ex - ey;
    dsh  = (diff > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : diff[SH_W-1:0];
    wide = {sy, {EXT_W{1'b0}}} >> dsh;

    st_d.sign     = x[WORD_W-1];
    st_d.mx       = {sx, 3'b000};
    st_d.my       = {wide[WIDE_W-1 -: EXT_W-1], wide[SIG_W] | (|wide[SIG_W-1:0])};
    st_d.ex       = ex;
    st_d.eff_sub  = x[WORD_W-1] ^ y[WORD_W-1];
    st_d.special  = &ex;
    st_d.spec_val = x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      st_o    <= '0;
    end else begin
      valid_o <= valid_i;
      st_o    <= st_d;
    end
  end

  p_align_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (st_o.mx >= st_o.my));
  p_valid_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  align_t st_i,
  output logic   valid_o,
  output norm_t  st_o
);
  logic [EXT_W:0]   sum;
  logic [SH_W-1:0]  lz;
  norm_t            st_d;

  always_comb begin
    sum = st_i.eff_sub ? ({1'b0, st_i.mx} - {1'b0, st_i.my})
                       : ({1'b0, st_i.mx} + {1'b0, st_i.my});
    lz  = lead_zeros(sum[EXT_W-1:0]);
    st_d.sign     = st_i.sign;
    st_d.zero     = (sum == '0);
    st_d.special  = st_i.special;
    st_d.spec_val = st_i.spec_val;
    if (sum[EXT_W]) begin
      st_d.norm = {sum[EXT_W:2], sum[1] | sum[0]};
      st_d.exp  = $signed(ES_W'(st_i.ex)) + $signed(ES_W'(1));
    end else begin
      st_d.norm = sum[EXT_W-1:0] << lz;
      st_d.exp  = $signed(ES_W'(st_i.ex)) - $signed(ES_W'(lz));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      st_o    <= '0;
    end else begin
      valid_o <= valid_i;
      st_o    <= st_d;
    end
  end

  p_norm_msb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !st_o.zero && !st_o.special) |-> st_o.norm[EXT_W-1]);
  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  norm_t             st_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] y_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [SIG_W-1:0]       mant;
  logic                   up;
  logic [SIG_W:0]         m25;
  logic [FRAC_W-1:0]      frac;
  logic signed [ES_W-1:0] e2;
  logic [WORD_W-1:0]      y_d;
  logic                   ovf_d, unf_d;

  always_comb begin
    mant = st_i.norm[EXT_W-1:3];
    up   = st_i.norm[2] & (st_i.norm[1] | st_i.norm[0] | mant[0]);
    m25  = {1'b0, mant} + (SIG_W+1)'(up);
    frac = m25[SIG_W] ? m25[SIG_W-1:1] : m25[FRAC_W-1:0];
    e2   = st_i.exp + $signed(ES_W'(m25[SIG_W]));
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (st_i.special) begin
      y_d = st_i.spec_val;
    end else if (st_i.zero) begin
      y_d = '0;
    end else if (e2 >= $signed(ES_W'(EXP_MAX))) begin
      y_d   = {st_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else if (e2 < $signed(ES_W'(1))) begin
      y_d   = {st_i.sign, {(WORD_W-1){1'b0}}};
      unf_d = 1'b1;
    end else begin
      y_d = {st_i.sign, e2[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      y_o     <= y_d;
      ovf_o   <= ovf_d;
      unf_o   <= unf_d;
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpadd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] y_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic   v1, v2;
  align_t s1;
  norm_t  s2;

  fpadd_align u_align (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .sub_i,
    .valid_o(v1), .st_o(s1)
  );

  fpadd_norm u_norm (
    .clk_i, .rst_ni, .valid_i(v1), .st_i(s1),
    .valid_o(v2), .st_o(s2)
  );

  fpadd_round u_round (
    .clk_i, .rst_ni, .valid_i(v2), .st_i(s2),
    .valid_o, .y_o, .ovf_o, .unf_o
  );

  p_ovf_inf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (y_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  p_unf_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (y_o[WORD_W-2:0] == '0));
  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}));
  p_no_subnormal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_o[WORD_W-2:FRAC_W] == '0) |-> (y_o[FRAC_W-1:0] == '0));
endmodule

// File: tb/fp_addsub_test.sv
`timescale 1ns/1ps
module fp_addsub_test;
  localparam int NOPS = 600;
  localparam int NDIR = 21;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        sub_i = 1'b0;
  logic        valid_o;
  logic [31:0] y_o;
  logic        ovf_o, unf_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] ta [NOPS];
  logic [31:0] tb [NOPS];
  logic        ts [NOPS];
  logic        tv [NOPS];
  string       tag [NOPS];

  always #10 clk_i = ~clk_i;

  fp_addsub uut (.*);

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", r, what, act, exp_v);
    end
  endtask

  function automatic logic [63:0] f2d(input logic [31:0] x);
    if (x[30:23] == 8'd0) return 64'd0;
    return {x[31], {3'b000, x[30:23]} + 11'd896, x[22:0], 29'd0};
  endfunction

  // returns {ovf, unf, y}
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [31:0] be;
    logic [63:0] bits;
    real r;
    int e;
    logic [52:0] m;
    logic [24:0] k25;
    logic [23:0] keep;
    logic up;
    be = {b[31] ^ s, b[30:0]};
    if ((&a[30:23]) || (&b[30:23]))
      return {2'b00, (a[30:0] >= b[30:0]) ? a : be};
    r = $bitstoreal(f2d(a)) + $bitstoreal(f2d(be));
    if (r == 0.0) return 34'd0;
    bits = $realtobits(r);
    e = int'(bits[62:52]) - 896;
    m = {1'b1, bits[51:0]};
    up = m[28] & ((|m[27:0]) | m[29]);
    k25 = {1'b0, m[52:29]} + 25'(up);
    if (k25[24]) begin
      e++;
      keep = k25[24:1];
    end else begin
      keep = k25[23:0];
    end
    if (e >= 255) return {2'b10, bits[63], 8'hFF, 23'd0};
    if (e <= 0) return {2'b01, bits[63], 31'd0};
    return {2'b00, bits[63], e[7:0], keep[22:0]};
  endfunction

  task automatic put(input int i, input logic [31:0] a, input logic [31:0] b, input logic s, input string r);
    ta[i] = a; tb[i] = b; ts[i] = s; tv[i] = 1'b1; tag[i] = r;
  endtask

  initial begin
    logic [33:0] ex;
    void'($urandom(32'd2024));
    // directed corner cases
    put(0,  32'h3f800000, 32'h3f800000, 1'b0, "R1");
    put(1,  32'h40400000, 32'h3f800000, 1'b1, "R1");
    put(2,  32'h3f800000, 32'h40000000, 1'b1, "R5");
    put(3,  32'hc0000000, 32'h3f800000, 1'b0, "R5");
    put(4,  32'h3f800000, 32'h3f800000, 1'b1, "R6");
    put(5,  32'h80000000, 32'h80000000, 1'b0, "R6");
    put(6,  32'h00000000, 32'h00000000, 1'b1, "R6");
    put(7,  32'h7f7fffff, 32'h7f7fffff, 1'b0, "R3");
    put(8,  32'hff7fffff, 32'h7f7fffff, 1'b1, "R3");
    put(9,  32'h00800000, 32'h00800001, 1'b1, "R4");
    put(10, 32'h00800001, 32'h00800000, 1'b1, "R4");
    put(11, 32'h7fc00000, 32'h3f800000, 1'b0, "R7");
    put(12, 32'h3f800000, 32'h7f800000, 1'b1, "R7");
    put(13, 32'h7f800000, 32'hff800000, 1'b0, "R7");
    put(14, 32'h3f800000, 32'h33800000, 1'b0, "R2");
    put(15, 32'h3f800001, 32'h33800000, 1'b0, "R2");
    put(16, 32'h3f800000, 32'h00000001, 1'b0, "R1");
    put(17, 32'h3f800001, 32'h3f800000, 1'b1, "R10");
    put(18, 32'h4b7fffff, 32'h3f000000, 0, "R2");
    put(19, 32'h00000000, 32'h00000000, 1'b0, "R8"); tv[19] = 1'b0;
    put(20, 32'h00000000, 32'h00000000, 1'b0, "R8"); tv[20] = 1'b0;
    // random families
    for (int i = NDIR; i < NOPS; i++) begin
      logic [31:0] a, b;
      int fam;
      a = $urandom;
      fam = $urandom % 4;
      case (fam)
        0: b = $urandom;
        1: b = {1'(($urandom)), 8'(a[30:23] + 8'(($urandom % 5)) - 8'd2), 23'(($urandom))};
        2: b = {~a[31], a[30:4], 4'(($urandom))};
        default: begin
          a[30:23] = ($urandom % 2 == 0) ? 8'(($urandom % 3) + 1) : 8'(252 + ($urandom % 3));
          b = {1'(($urandom)), a[30:23], 23'(($urandom))};
        end
      endcase
      put(i, a, b, 1'($urandom), (fam == 2) ? "R10" : "R2");
      if ($urandom % 10 == 0) begin
        tv[i] = 1'b0;
        tag[i] = "R8";
      end
    end

    // reset state
    repeat (3) @(negedge clk_i);
    chk("R9", "valid_o in reset", 32'(valid_o), 32'd0);
    chk("R9", "y_o in reset", y_o, 32'd0);
    chk("R9", "flags in reset", {30'd0, ovf_o, unf_o}, 32'd0);
    rst_ni = 1'b1;

    for (int c = 0; c < NOPS + 3; c++) begin
      @(negedge clk_i);
      if (c >= 3) begin
        int k;
        k = c - 3;
        chk("R8", "valid_o", 32'(valid_o), 32'(tv[k]));
        if (tv[k]) begin
          ex = ref_add(ta[k], tb[k], ts[k]);
          chk(tag[k], $sformatf("y_o op %0d", k), y_o, ex[31:0]);
          chk(ex[33] ? "R3" : tag[k], $sformatf("ovf_o op %0d", k), 32'(ovf_o), 32'(ex[33]));
          chk(ex[32] ? "R4" : tag[k], $sformatf("unf_o op %0d", k), 32'(unf_o), 32'(ex[32]));
        end
      end
      if (c < NOPS) begin
        valid_i = tv[c];
        a_i = ta[c];
        b_i = tb[c];
        sub_i = ts[c];
      end else begin
        valid_i = 1'b0;
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule